// File: doc/BRIEF.md
# Single-Shot A-to-B Interval Gate

This block times one interval between two event pulses. A strobe arms it. The first A event after arming sets a start latch, and the counting gate opens on the next rising edge of the reference clock. While the gate is open, a counter advances either on every reference clock or once every 10^N clocks. N is sampled when the block is armed.

A B event that arrives while the gate is open sets a stop latch. The next clock edge closes the gate, and counting stops on that edge. The block then spends one clock in a flush phase that clears both latches. After that it raises `done` and holds the result until the next arm strobe.

An arm strobe at any time aborts the measurement in progress and clears the count and the overflow flag. The count width and the largest exponent are parameters.

Top module: `ab_interval_gate`

## Requirements
- R1: After reset, `gate_open`, `done`, `overflow` are 0 and `count` is 0; A and B events are ignored until the first arm strobe.
- R2: An arm strobe sampled at a clock edge aborts any measurement, and after that edge `count`, `done`, `overflow` and `gate_open` are all 0; events sampled on that same edge are ignored.
- R3: The first A event sampled at edge k after arming makes `gate_open` high after edge k+1.
- R4: A B event sampled while the gate is not yet open is ignored.
- R5: A B event sampled at edge m while the gate is open makes `gate_open` low after edge m+1, and edge m+1 adds no count.
- R6: With A at edge k and B at edge m, the final count is floor((m-k-1)/10^N). The divider restarts when the gate opens, so the first count takes a full 10^N clocks.
- R7: `done` goes high after edge m+2, and both `done` and `count` hold until the next arm strobe.
- R8: The count wraps modulo 2^COUNT_W. `overflow` is set on the wrap and stays set until the next arm strobe.
- R9: An exponent input larger than MAX_EXP is treated as MAX_EXP.
- R10: Further A events while the gate is open, or after `done`, neither restart nor reopen the measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also the counted signal |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm / abort strobe, one clock wide |
| ev_a | input | 1 | Start event pulse |
| ev_b | input | 1 | Stop event pulse |
| div_exp | input | EXP_W | Prescale exponent N, sampled on arm |
| gate_open | output | 1 | Counting gate state |
| done | output | 1 | Measurement complete, result held |
| count | output | COUNT_W | Interval count |
| overflow | output | 1 | Sticky wrap flag |

## Verification
The hardest condition to reach is the counter wrap: at full width it would take billions of clocks. The bench therefore builds the block with an 8-bit count and holds the gate open for 300 undivided clocks, which forces one wrap. It then aborts with a new arm to show that the flag clears. The second hard case is the clamped exponent. Here the bench arms with N=7 and keeps the gate open for 25000 clocks, so that the result separates a divide-by-10^4 from any other divisor.

// File: rtl/ab_gate_pkg.sv
`timescale 1ns/1ps
package ab_gate_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_OPEN,
      ST_FLUSH,
      ST_DONE
   } gate_state_e;

   function automatic int unsigned pow10(input int unsigned e);
      int unsigned v;
      v = 1;
      for (int unsigned i = 0; i < e; i++) v = v * 10;
      return v;
   endfunction
endpackage

// File: rtl/abg_event_latch.sv
`timescale 1ns/1ps
module abg_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (set) q <= 1'b1;
   end
endmodule

// File: rtl/abg_decade_prescaler.sv
`timescale 1ns/1ps
module abg_decade_prescaler
   import ab_gate_pkg::*;
#(
   parameter int MAX_EXP = 4,
   parameter int EXP_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             tick
);
   generate
      if (MAX_EXP == 0) begin : g_bypass
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, run, exp_sel};
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int PW = $clog2(pow10(MAX_EXP));
         logic [PW-1:0] cnt;
         logic [PW-1:0] lim;

         always_comb begin
            lim = '0;
            for (int i = 0; i <= MAX_EXP; i++) begin
               if (exp_sel == EXP_W'(i)) lim = PW'(pow10(i) - 1);
            end
         end

         assign tick = (cnt == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (!run) cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/abg_interval_counter.sv
`timescale 1ns/1ps
module abg_interval_counter #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               inc,
   output logic [COUNT_W-1:0] value,
   output logic               wrapped
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value   <= '0;
         wrapped <= 1'b0;
      end else if (clr) begin
         value   <= '0;
         wrapped <= 1'b0;
      end else if (inc) begin
         value <= value + 1'b1;
         if (&value) wrapped <= 1'b1;
      end
   end
endmodule

// File: rtl/ab_interval_gate.sv
`timescale 1ns/1ps
module ab_interval_gate
   import ab_gate_pkg::*;
#(
   parameter int COUNT_W = 32,
   parameter int MAX_EXP = 4,
   parameter int EXP_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               ev_a,
   input  logic               ev_b,
   input  logic [EXP_W-1:0]   div_exp,
   output logic               gate_open,
   output logic               done,
   output logic [COUNT_W-1:0] count,
   output logic               overflow
);
   generate
      if (COUNT_W < 2) begin : g_bad_count_w
         $error("COUNT_W must be at least 2");
      end
      if (MAX_EXP < 0 || MAX_EXP > 9) begin : g_bad_max_exp
         $error("MAX_EXP must lie in 0..9");
      end
      if (MAX_EXP >= (1 << EXP_W)) begin : g_bad_exp_w
         $error("EXP_W too narrow for MAX_EXP");
      end
   endgenerate

   gate_state_e      st;
   logic [EXP_W-1:0] exp_q;
   logic             start_q, stop_q, tick, flush;

   assign flush = (st == ST_FLUSH);

   abg_event_latch u_start (
      .clk(clk), .rst_n(rst_n),
      .set(ev_a && st == ST_ARMED && !arm),
      .clr(arm || flush),
      .q(start_q)
   );

   abg_event_latch u_stop (
      .clk(clk), .rst_n(rst_n),
      .set(ev_b && st == ST_OPEN && !arm),
      .clr(arm || flush),
      .q(stop_q)
   );

   abg_decade_prescaler #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .run(st == ST_OPEN),
      .exp_sel(exp_q),
      .tick(tick)
   );

   abg_interval_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(arm),
      .inc(st == ST_OPEN && !stop_q && tick && !arm),
      .value(count),
      .wrapped(overflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         exp_q <= '0;
      end else if (arm) begin
         st    <= ST_ARMED;
         exp_q <= (div_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : div_exp;
      end else begin
         case (st)
            ST_ARMED: if (start_q) st <= ST_OPEN;
            ST_OPEN:  if (stop_q)  st <= ST_FLUSH;
            ST_FLUSH: st <= ST_DONE;
            default:  st <= st;
         endcase
      end
   end

   assign gate_open = (st == ST_OPEN);
   assign done      = (st == ST_DONE);
endmodule

// File: rtl/abg_checker.sv
`timescale 1ns/1ps
module abg_checker #(
   parameter int COUNT_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               arm,
   input logic               ev_a,
   input logic               ev_b,
   input logic               gate_open,
   input logic               done,
   input logic [COUNT_W-1:0] count,
   input logic               overflow
);
   assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (count == '0 && !done && !gate_open && !overflow));

   assert_open_after_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_open) |-> $past(ev_a, 2));

   assert_close_after_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_open) && !$past(arm)) |-> $past(ev_b, 2));

   assert_done_after_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(gate_open, 2));

   assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> (done && $stable(count)));

   assert_count_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && !arm) |=> $stable(count));

   assert_no_overflow_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !arm) |=> overflow);

   assert_gate_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_open && done));
endmodule

bind ab_interval_gate abg_checker #(.COUNT_W(COUNT_W)) u_abg_checker (
   .clk(clk), .rst_n(rst_n), .arm(arm), .ev_a(ev_a), .ev_b(ev_b),
   .gate_open(gate_open), .done(done), .count(count), .overflow(overflow)
);

// File: tb/ab_interval_gate_test.sv
`timescale 1ns/1ps
module ab_interval_gate_test;
   localparam int TW = 8;
   localparam int TMAX = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0, ev_a = 1'b0, ev_b = 1'b0;
   logic [2:0]    div_exp = 3'd0;
   logic          gate_open, done, overflow;
   logic [TW-1:0] count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   ab_interval_gate #(.COUNT_W(TW), .MAX_EXP(TMAX), .EXP_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .ev_a(ev_a), .ev_b(ev_b),
      .div_exp(div_exp), .gate_open(gate_open), .done(done),
      .count(count), .overflow(overflow)
   );

   always #4 clk = ~clk;

   // Behavioural reference: edge indices of the recorded events
   longint e_now, a_at, b_at, divisor;
   bit     m_armed;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_now = 0; a_at = -1; b_at = -1; divisor = 1; m_armed = 0;
      end else begin
         e_now++;
         if (arm) begin
            m_armed = 1; a_at = -1; b_at = -1;
            divisor = 1;
            for (int i = 0; i < ((div_exp > TMAX) ? TMAX : int'(div_exp)); i++)
               divisor = divisor * 10;
         end else if (m_armed && a_at < 0 && ev_a) begin
            a_at = e_now;
         end else if (a_at >= 0 && e_now >= a_at + 2 && b_at < 0 && ev_b) begin
            b_at = e_now;
         end
      end
   end

   function automatic longint model_ticks();
      longint last;
      last = (b_at >= 0) ? b_at : e_now;
      if (a_at >= 0 && last >= a_at + 2) return (last - a_at - 1) / divisor;
      return 0;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && e_now > 0) begin
         longint t;
         t = model_ticks();
         chk("R3/R5 gate_open", gate_open,
             (a_at >= 0 && e_now >= a_at + 1 && (b_at < 0 || e_now <= b_at)) ? 1 : 0);
         chk("R7 done", done, (b_at >= 0 && e_now >= b_at + 2) ? 1 : 0);
         chk("R6 count", count, t % (64'd1 << TW));
         chk("R8 overflow", overflow, (t >= (64'd1 << TW)) ? 1 : 0);
      end
   end

   task automatic pulse_arm(input int n);
      @(negedge clk); div_exp = 3'(n); arm = 1'b1;
      @(negedge clk); arm = 1'b0;
   endtask
   task automatic pulse_a();
      @(negedge clk); ev_a = 1'b1;
      @(negedge clk); ev_a = 1'b0;
   endtask
   task automatic pulse_b();
      @(negedge clk); ev_b = 1'b1;
      @(negedge clk); ev_b = 1'b0;
   endtask
   // A, then g idle clocks, then B: expected count floor(g / 10^N)
   task automatic interval(input int g);
      pulse_a();
      repeat (g - 1) @(negedge clk);
      pulse_b();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset gate", gate_open, 0);
      chk("R1 reset done", done, 0);
      chk("R1 reset count", count, 0);
      chk("R1 reset overflow", overflow, 0);
      rst_n = 1'b1;
      // R1: events before any arm are ignored
      pulse_a(); repeat (5) @(negedge clk); pulse_b(); repeat (3) @(negedge clk);
      chk("R1 idle gate", gate_open, 0);
      chk("R1 idle done", done, 0);

      // R4: B before A ignored, then N=0 interval
      pulse_arm(0);
      pulse_b(); repeat (3) @(negedge clk);
      chk("R4 early B gate", gate_open, 0);
      chk("R4 early B done", done, 0);
      interval(20);
      chk("R6 N0 count", count, 20);
      chk("R7 done set", done, 1);
      // R10/R7: events after done change nothing
      pulse_a(); repeat (12) @(negedge clk); pulse_b(); repeat (3) @(negedge clk);
      chk("R10 after done count", count, 20);
      chk("R7 held done", done, 1);

      // R6: N=1 and N=2
      pulse_arm(1); interval(57);
      chk("R6 N1 count", count, 5);
      pulse_arm(2); interval(250);
      chk("R6 N2 count", count, 2);

      // R10: second A while open does not restart
      pulse_arm(0);
      pulse_a(); repeat (9) @(negedge clk);
      pulse_a(); repeat (8) @(negedge clk);
      pulse_b(); repeat (3) @(negedge clk);
      chk("R10 reA count", count, 20);

      // R9: exponent 7 clamped to 4
      pulse_arm(7); interval(25000);
      chk("R9 clamp count", count, 2);

      // R8: wrap with 8-bit count
      pulse_arm(0); interval(300);
      chk("R8 wrap count", count, 300 % 256);
      chk("R8 overflow set", overflow, 1);

      // R2: arm clears overflow, then abort an open measurement
      pulse_arm(0);
      chk("R2 arm clears overflow", overflow, 0);
      chk("R2 arm clears done", done, 0);
      pulse_a(); repeat (10) @(negedge clk);
      chk("R3 gate open", gate_open, 1);
      pulse_arm(0);
      chk("R2 abort gate", gate_open, 0);
      chk("R2 abort count", count, 0);
      // R2: A on the arm edge ignored
      @(negedge clk); arm = 1'b1; ev_a = 1'b1;
      @(negedge clk); arm = 1'b0; ev_a = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 same-edge A", gate_open, 0);
      interval(15);
      chk("R6 after abort", count, 15);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule